// File: doc/BRIEF.md
# Chained-Descriptor DMA Channel

This block is the transfer engine of a single DMA channel. Software places a chain of descriptors in memory and gives the engine the address of the first one together with a run pulse. The engine reads each four-word descriptor, copies the stated number of bytes from the source to the target in bursts over a simple request/response memory port, and then follows the descriptor's link word to the next descriptor. A set stop flag in the link word ends the chain. A link that points back to an earlier descriptor makes the channel loop without end, which gives cyclic (ring buffer) transfers.

Both address counters are visible on ports while the channel runs, so software can work out how many bytes remain in the current descriptor. Per-descriptor command bits choose the access width, the burst length, whether each address steps, and whether the transfer waits for a peripheral ready line before each burst. The engine pulses start, end and bus-error events for an interrupt controller.

Top module: `dma_chain_engine`

## Requirements
- R1: A run pulse while idle starts a fetch at `desc_addr_i` with bits 3:0 forced to zero. The four descriptor words are read at offsets +0 (link), +4 (source), +8 (target) and +12 (command). A run pulse while the engine is busy is ignored.
- R2: Each beat reads the source, then writes the read data unchanged to the target. The beat size is given by command bits 15:14: 1 gives 1 byte, 2 gives 2 bytes, and 3 or 0 gives 4 bytes. The size appears on `mem_size_o`, and the data sits in the low bytes of the data word.
- R3: Command bits 12:0 give the byte count. Exactly that many bytes are written. The last burst and the last beat are cut short to fit. A count of zero moves no data.
- R4: Command bits 17:16 set the burst length: 2 gives 16 bytes, 3 gives 32 bytes, and 1 or 0 gives 8 bytes. When command bit 29 (source paces) or bit 28 (target paces) is set, no source read of a burst is issued until `periph_ready_i` is high. When both bits are clear, `periph_ready_i` is ignored.
- R5: Command bit 31 makes the source address step by the beat size after each beat, and bit 30 does the same for the target address. When a bit is clear, that address stays fixed.
- R6: `cur_src_o` and `cur_dst_o` hold the next source and target addresses. After a descriptor completes, they equal its start addresses plus the bytes moved on each stepping side.
- R7: `evt_start_o` pulses once when a descriptor with command bit 22 set has been loaded. `evt_end_o` pulses once when a descriptor with command bit 21 set has completed.
- R8: After a descriptor completes, the engine goes idle (`busy_o` low) if bit 0 of its link word is set. Otherwise it fetches the next descriptor at the link word with bits 3:0 cleared. A backward link repeats the loop, with an end event after every descriptor.
- R9: An error response on the memory port pulses `evt_err_o`. The channel then halts: `busy_o` goes low, no further request is made, and no further write takes place. A later run pulse starts the channel again.
- R10: `mem_req_o`, `mem_we_o`, `mem_addr_o`, `mem_size_o` and `mem_wdata_o` stay steady from the moment a request is raised until the cycle that `mem_rsp_i` answers it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Start pulse |
| desc_addr_i | input | 32 | Address of the first descriptor |
| periph_ready_i | input | 1 | Peripheral ready for the next burst |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Byte address |
| mem_size_o | output | 3 | Bytes in this access (1, 2 or 4) |
| mem_wdata_o | output | 32 | Write data, low bytes used |
| mem_rsp_i | input | 1 | Response for the pending request |
| mem_err_i | input | 1 | Response carries an error |
| mem_rdata_i | input | 32 | Read data, low bytes used |
| cur_src_o | output | 32 | Live source address |
| cur_dst_o | output | 32 | Live target address |
| busy_o | output | 1 | Channel is running |
| evt_start_o | output | 1 | Descriptor-start event |
| evt_end_o | output | 1 | Descriptor-end event |
| evt_err_o | output | 1 | Bus-error event |

## Verification
The copy path is tried with word, halfword and byte beats. The lengths are either whole bursts or odd, which shows whether the last burst and the last beat are cut short correctly. A paced descriptor with a fixed target, held back by a low ready line, separates correct flow control and address holding from an engine that streams regardless. Tests with a two-descriptor chain, a zero-length link, a backward link that software later stops, and a source in an erroring region show the link-following, loop, skip and halt paths apart. A run pulse sent in the middle of a chain shows whether the engine wrongly restarts.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  localparam int LEN_W   = 13;
  localparam int BURST_W = 6;

  // command word field positions
  localparam int CMD_INC_SRC = 31;
  localparam int CMD_INC_DST = 30;
  localparam int CMD_PACE_S  = 29;
  localparam int CMD_PACE_T  = 28;
  localparam int CMD_IRQ_ST  = 22;
  localparam int CMD_IRQ_END = 21;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_LOAD, ST_WAIT, ST_RD, ST_WR, ST_END
  } chan_state_e;

  function automatic logic [2:0] width_bytes(input logic [1:0] code);
    case (code)
      2'd1:    return 3'd1;
      2'd2:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [BURST_W-1:0] burst_bytes(input logic [1:0] code);
    case (code)
      2'd2:    return BURST_W'(16);
      2'd3:    return BURST_W'(32);
      default: return BURST_W'(8);
    endcase
  endfunction

  // bytes in the next burst: the burst length, or what is left if smaller
  function automatic logic [BURST_W-1:0] fit_len(input logic [LEN_W-1:0] left,
                                                 input logic [BURST_W-1:0] cap);
    return (left < LEN_W'(cap)) ? left[BURST_W-1:0] : cap;
  endfunction

  function automatic logic [31:0] step_addr(input logic [31:0] a, input logic inc,
                                            input logic [2:0] beat);
    return inc ? a + 32'(beat) : a;
  endfunction
endpackage

// File: rtl/dma_chain_count.sv
module dma_chain_count
  import dma_chain_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [LEN_W-1:0]   load_len,
  input  logic               burst_go,
  input  logic [1:0]         burst_code,
  input  logic [1:0]         width_code,
  input  logic               beat_done,
  output logic [LEN_W-1:0]   rem_o,
  output logic [BURST_W-1:0] burst_left_o,
  output logic [2:0]         beat_o
);
  logic [2:0] wb;

  always_comb begin
    wb = width_bytes(width_code);
    beat_o = (BURST_W'(wb) > burst_left_o) ? burst_left_o[2:0] : wb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_o <= '0;
      burst_left_o <= '0;
    end else begin
      if (load) rem_o <= load_len;
      else if (beat_done) rem_o <= rem_o - LEN_W'(beat_o);
      if (burst_go) burst_left_o <= fit_len(rem_o, burst_bytes(burst_code));
      else if (beat_done) burst_left_o <= burst_left_o - BURST_W'(beat_o);
    end
  end

  // R3: a completed beat never moves more bytes than remain
  assert_beat_fits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    beat_done |-> (LEN_W'(beat_o) <= rem_o) && (beat_o != 3'd0));
endmodule

// File: rtl/dma_chain_addr.sv
module dma_chain_addr
  import dma_chain_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          src_load,
  input  logic          dst_load,
  input  logic [AW-1:0] load_val,
  input  logic          beat_done,
  input  logic [2:0]    beat,
  input  logic          inc_src,
  input  logic          inc_dst,
  output logic [AW-1:0] cur_src_o,
  output logic [AW-1:0] cur_dst_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_src_o <= '0;
      cur_dst_o <= '0;
    end else begin
      if (src_load) cur_src_o <= load_val;
      else if (beat_done) cur_src_o <= AW'(step_addr(32'(cur_src_o), inc_src, beat));
      if (dst_load) cur_dst_o <= load_val;
      else if (beat_done) cur_dst_o <= AW'(step_addr(32'(cur_dst_o), inc_dst, beat));
    end
  end

  // R5: a non-stepping side keeps its address across a beat
  assert_src_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_done && !inc_src && !src_load) |=> $stable(cur_src_o));
  assert_dst_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_done && !inc_dst && !dst_load) |=> $stable(cur_dst_o));
endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine
  import dma_chain_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic [AW-1:0] desc_addr_i,
  input  logic          periph_ready_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [2:0]    mem_size_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_rsp_i,
  input  logic          mem_err_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] cur_src_o,
  output logic [AW-1:0] cur_dst_o,
  output logic          busy_o,
  output logic          evt_start_o,
  output logic          evt_end_o,
  output logic          evt_err_o
);
  localparam int IDX_W = 2;

  chan_state_e state;
  logic [AW-1:0]      desc_ptr, link_word;
  logic [31:0]        cmd_word;
  logic [IDX_W-1:0]   fidx;
  logic [DW-1:0]      data_q;
  logic [LEN_W-1:0]   rem;
  logic [BURST_W-1:0] burst_left;
  logic [2:0]         beat;

  // named internal events
  logic rsp_ok, rsp_err, fetch_ok, burst_go, beat_done, paced;
  assign rsp_ok    = mem_req_o && mem_rsp_i && !mem_err_i;
  assign rsp_err   = mem_req_o && mem_rsp_i && mem_err_i;
  assign fetch_ok  = (state == ST_FETCH) && rsp_ok;
  assign paced     = cmd_word[CMD_PACE_S] || cmd_word[CMD_PACE_T];
  assign burst_go  = (state == ST_WAIT) && (!paced || periph_ready_i);
  assign beat_done = (state == ST_WR) && rsp_ok;

  dma_chain_count u_count (
    .clk, .rst_n,
    .load(state == ST_LOAD), .load_len(cmd_word[LEN_W-1:0]),
    .burst_go, .burst_code(cmd_word[17:16]), .width_code(cmd_word[15:14]),
    .beat_done, .rem_o(rem), .burst_left_o(burst_left), .beat_o(beat)
  );

  dma_chain_addr #(.AW(AW)) u_addr (
    .clk, .rst_n,
    .src_load(fetch_ok && fidx == 2'd1), .dst_load(fetch_ok && fidx == 2'd2),
    .load_val(AW'(mem_rdata_i)), .beat_done, .beat,
    .inc_src(cmd_word[CMD_INC_SRC]), .inc_dst(cmd_word[CMD_INC_DST]),
    .cur_src_o, .cur_dst_o
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      desc_ptr <= '0;
      link_word <= '0;
      cmd_word <= '0;
      fidx <= '0;
      data_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (run_i) begin
          desc_ptr <= {desc_addr_i[AW-1:4], 4'b0};
          fidx <= '0;
          state <= ST_FETCH;
        end
        ST_FETCH: if (rsp_err) state <= ST_IDLE;
        else if (rsp_ok) begin
          if (fidx == 2'd0) link_word <= AW'(mem_rdata_i);
          if (fidx == 2'd3) begin
            cmd_word <= 32'(mem_rdata_i);
            state <= ST_LOAD;
          end
          fidx <= fidx + 1'b1;
        end
        ST_LOAD: state <= (cmd_word[LEN_W-1:0] == '0) ? ST_END : ST_WAIT;
        ST_WAIT: if (burst_go) state <= ST_RD;
        ST_RD: if (rsp_err) state <= ST_IDLE;
        else if (rsp_ok) begin
          data_q <= mem_rdata_i;
          state <= ST_WR;
        end
        ST_WR: if (rsp_err) state <= ST_IDLE;
        else if (rsp_ok) begin
          if (rem == LEN_W'(beat)) state <= ST_END;
          else if (burst_left == BURST_W'(beat)) state <= ST_WAIT;
          else state <= ST_RD;
        end
        ST_END: if (link_word[0]) state <= ST_IDLE;
        else begin
          desc_ptr <= {link_word[AW-1:4], 4'b0};
          fidx <= '0;
          state <= ST_FETCH;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o   = (state == ST_FETCH) || (state == ST_RD) || (state == ST_WR);
    mem_we_o    = (state == ST_WR);
    mem_wdata_o = data_q;
    mem_size_o  = (state == ST_FETCH) ? 3'd4 : beat;
    case (state)
      ST_FETCH: mem_addr_o = desc_ptr + AW'({fidx, 2'b00});
      ST_WR:    mem_addr_o = cur_dst_o;
      default:  mem_addr_o = cur_src_o;
    endcase
  end

  assign busy_o      = (state != ST_IDLE);
  assign evt_start_o = (state == ST_LOAD) && cmd_word[CMD_IRQ_ST];
  assign evt_end_o   = (state == ST_END) && cmd_word[CMD_IRQ_END];
  assign evt_err_o   = rsp_err;

  // R10: a pending request holds still until answered
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_rsp_i) |=> mem_req_o && $stable(mem_addr_o) &&
      $stable(mem_we_o) && $stable(mem_size_o) && $stable(mem_wdata_o));
  // R9: an error response halts the channel
  assert_err_halts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_err_o |=> !busy_o && !mem_req_o);
  // R4: a paced burst does not begin while the peripheral is not ready
  assert_pace_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_WAIT) && paced && !periph_ready_i) |=> (state == ST_WAIT));
  // R7: start and end events never coincide
  assert_evt_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_start_o, evt_end_o, evt_err_o}));
  // R1: a run pulse while busy does not move the descriptor pointer
  assert_run_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && busy_o && state != ST_END) |=> $stable(desc_ptr));
endmodule

// File: tb/dma_chain_engine_tb.sv
module dma_chain_engine_tb;
  localparam int MEMB = 4096;
  localparam logic [31:0] ERR_BASE = 32'h0001_0000;

  logic clk = 0, rst_n = 0;
  logic run_i = 0, periph_ready_i = 1;
  logic [31:0] desc_addr_i = '0;
  logic mem_req_o, mem_we_o, busy_o, evt_start_o, evt_end_o, evt_err_o;
  logic [31:0] mem_addr_o, mem_wdata_o, cur_src_o, cur_dst_o;
  logic [2:0] mem_size_o;
  logic mem_rsp_i = 0, mem_err_i = 0;
  logic [31:0] mem_rdata_i = '0;

  always #2ns clk = ~clk;

  dma_chain_engine u_dut (.*);

  logic [7:0] mem [0:MEMB-1];
  int checks = 0, errors = 0, cyc = 0;
  int n_start = 0, n_end = 0, n_err = 0, stall_reqs = 0;
  bit stall = 0, finished = 0;
  logic [31:0] q_addr[$], q_data[$];
  int q_size[$];
  logic [31:0] exp_src, exp_dst;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rdn(input logic [31:0] a, input int n);
    logic [31:0] v = '0;
    for (int i = 0; i < n; i++) v[8*i +: 8] = mem[(a + i) % MEMB];
    return v;
  endfunction

  task automatic wr32(input logic [31:0] a, input logic [31:0] v);
    for (int i = 0; i < 4; i++) mem[a + i] = v[8*i +: 8];
  endtask

  task automatic set_desc(input logic [31:0] b, input logic [31:0] lnk, input logic [31:0] s,
                          input logic [31:0] d, input logic [31:0] c);
    wr32(b, lnk); wr32(b + 4, s); wr32(b + 8, d); wr32(b + 12, c);
  endtask

  function automatic logic [31:0] mk_cmd(input bit is, input bit id, input bit ps, input bit pt,
      input bit st, input bit en, input logic [1:0] bu, input logic [1:0] wi, input int len);
    logic [31:0] c = '0;
    c[31] = is; c[30] = id; c[29] = ps; c[28] = pt; c[22] = st; c[21] = en;
    c[17:16] = bu; c[15:14] = wi; c[12:0] = len[12:0];
    return c;
  endfunction

  // driver side of the scoreboard: expected writes of one descriptor, from R2..R5
  task automatic expect_desc(input logic [31:0] ptr);
    logic [31:0] s, d, c;
    int rem, bl, beat, w, b;
    s = rdn(ptr + 4, 4); d = rdn(ptr + 8, 4); c = rdn(ptr + 12, 4);
    rem = int'(c[12:0]);
    w = (c[15:14] == 2'd1) ? 1 : (c[15:14] == 2'd2) ? 2 : 4;
    b = (c[17:16] == 2'd2) ? 16 : (c[17:16] == 2'd3) ? 32 : 8;
    while (rem > 0) begin
      bl = (rem < b) ? rem : b;
      rem -= bl;
      while (bl > 0) begin
        beat = (w < bl) ? w : bl;
        bl -= beat;
        q_addr.push_back(d); q_size.push_back(beat); q_data.push_back(rdn(s, beat));
        if (c[31]) s += beat;
        if (c[30]) d += beat;
      end
    end
    exp_src = s; exp_dst = d;
  endtask

  // memory model and monitor side of the scoreboard
  always @(negedge clk) begin
    if (mem_rsp_i) begin
      mem_rsp_i = 0; mem_err_i = 0;
    end else if (mem_req_o) begin
      mem_rsp_i = 1;
      if (stall && (mem_we_o || mem_addr_o >= 32'h400)) stall_reqs++;
      if (mem_addr_o >= ERR_BASE) mem_err_i = 1;
      else if (mem_we_o) begin
        if (q_addr.size() == 0) chk(0, "R3 unexpected write", mem_addr_o, 0);
        else begin
          logic [31:0] ea, ed, msk;
          int es;
          ea = q_addr.pop_front(); es = q_size.pop_front(); ed = q_data.pop_front();
          msk = (es == 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * es)) - 1);
          chk(mem_addr_o == ea, "R5 write address", mem_addr_o, ea);
          chk(int'(mem_size_o) == es, "R3 beat size", 32'(mem_size_o), 32'(es));
          chk((mem_wdata_o & msk) == ed, "R2 write data", mem_wdata_o & msk, ed);
        end
        for (int i = 0; i < int'(mem_size_o); i++)
          mem[(mem_addr_o + i) % MEMB] = mem_wdata_o[8*i +: 8];
      end else mem_rdata_i = rdn(mem_addr_o, int'(mem_size_o));
    end
  end

  always @(posedge clk) begin
    if (evt_start_o) n_start++;
    if (evt_end_o) n_end++;
    if (evt_err_o) n_err++;
  end

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      report();
    end
  end

  task automatic kick(input logic [31:0] a);
    @(negedge clk); run_i = 1; desc_addr_i = a;
    @(negedge clk); run_i = 0;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (busy_o) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic end_test(input string tag);
    chk(q_addr.size() == 0, tag, 32'(q_addr.size()), 0);
    chk(cur_src_o == exp_src, "R6 final source", cur_src_o, exp_src);
    chk(cur_dst_o == exp_dst, "R6 final target", cur_dst_o, exp_dst);
  endtask

  initial begin
    int e0, s0;
    for (int i = 0; i < MEMB; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    // reset state
    chk(!busy_o && !mem_req_o, "R8 idle after reset", {busy_o, mem_req_o}, 0);
    chk(cur_src_o == 0 && cur_dst_o == 0, "R6 reset addresses", cur_src_o, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // T1: word beats, 8-byte bursts, 20 bytes; low address bits ignored (R1)
    set_desc(32'h000, 32'h1, 32'h400, 32'h800, mk_cmd(1,1,0,0,1,1,2'd1,2'd3,20));
    expect_desc(32'h000); s0 = n_start; e0 = n_end;
    kick(32'h00C); wait_idle();
    end_test("R1 word copy writes left");
    chk(n_start == s0 + 1, "R7 start event", n_start, s0 + 1);
    chk(n_end == e0 + 1, "R7 end event", n_end, e0 + 1);

    // T2: byte beats, odd length 5, source-paced with ready high
    set_desc(32'h040, 32'h1, 32'h421, 32'h841, mk_cmd(1,1,1,0,0,1,2'd2,2'd1,5));
    expect_desc(32'h040); s0 = n_start;
    kick(32'h040); wait_idle();
    end_test("R2 byte copy writes left");
    chk(n_start == s0, "R7 no start event when disabled", n_start, s0);

    // T3: shortened final burst 4,4,2 (R3)
    set_desc(32'h080, 32'h1, 32'h440, 32'h880, mk_cmd(1,1,0,0,0,0,2'd1,2'd3,10));
    expect_desc(32'h080);
    kick(32'h080); wait_idle();
    end_test("R3 short burst writes left");

    // T4: target-paced, fixed target, halfword beats, ready low for a while
    set_desc(32'h0C0, 32'h1, 32'h460, 32'h900, mk_cmd(1,0,0,1,0,1,2'd1,2'd2,12));
    expect_desc(32'h0C0);
    periph_ready_i = 0; stall = 1; stall_reqs = 0;
    kick(32'h0C0);
    repeat (40) @(negedge clk);
    chk(stall_reqs == 0, "R4 data access while not ready", stall_reqs, 0);
    chk(busy_o, "R4 waiting while not ready", busy_o, 1);
    stall = 0; periph_ready_i = 1;
    wait_idle();
    end_test("R4 paced copy writes left");
    chk(cur_dst_o == 32'h900, "R5 fixed target", cur_dst_o, 32'h900);

    // T5: two-descriptor chain; mid-chain run pulse ignored (R1)
    set_desc(32'h100, 32'h140, 32'h480, 32'h940, mk_cmd(1,1,0,0,0,0,2'd2,2'd3,24));
    set_desc(32'h140, 32'h1, 32'h4A0, 32'h980, mk_cmd(1,1,0,0,0,1,2'd3,2'd3,8));
    expect_desc(32'h100); expect_desc(32'h140); e0 = n_end;
    kick(32'h100);
    repeat (15) @(negedge clk);
    chk(busy_o, "R1 busy before second run", busy_o, 1);
    kick(32'h000);
    wait_idle();
    end_test("R8 chain writes left");
    chk(n_end == e0 + 1, "R7 end only where enabled", n_end, e0 + 1);

    // T6: zero-length descriptor links to a normal one (R3)
    set_desc(32'h180, 32'h1C0, 32'h4C0, 32'h9C0, mk_cmd(1,1,0,0,0,1,2'd1,2'd3,0));
    set_desc(32'h1C0, 32'h1, 32'h4D0, 32'h9D0, mk_cmd(1,1,0,0,0,1,2'd1,2'd3,4));
    expect_desc(32'h180); expect_desc(32'h1C0); e0 = n_end;
    kick(32'h180); wait_idle();
    end_test("R3 zero length writes left");
    chk(n_end == e0 + 2, "R3 zero length still ends", n_end, e0 + 2);

    // T7: cyclic ring A->B->A, stopped by software after one lap (R8)
    set_desc(32'h200, 32'h240, 32'h500, 32'hA00, mk_cmd(1,1,0,0,0,1,2'd1,2'd3,8));
    set_desc(32'h240, 32'h200, 32'h508, 32'hA08, mk_cmd(1,1,0,0,0,1,2'd1,2'd3,8));
    expect_desc(32'h200); expect_desc(32'h240);
    expect_desc(32'h200); expect_desc(32'h240); e0 = n_end;
    kick(32'h200);
    while (n_end < e0 + 2) @(negedge clk);
    wr32(32'h240, 32'h201);
    wait_idle();
    end_test("R8 cyclic writes left");
    chk(n_end == e0 + 4, "R8 end per cyclic descriptor", n_end, e0 + 4);

    // T8: error response halts; then restart works (R9)
    set_desc(32'h280, 32'h1, ERR_BASE, 32'hB00, mk_cmd(1,1,0,0,0,1,2'd1,2'd3,8));
    e0 = n_err;
    kick(32'h280);
    repeat (30) @(negedge clk);
    chk(n_err == e0 + 1, "R9 error event", n_err, e0 + 1);
    chk(!busy_o && !mem_req_o, "R9 halted", {busy_o, mem_req_o}, 0);
    chk(q_addr.size() == 0, "R9 no write after error", 32'(q_addr.size()), 0);
    expect_desc(32'h000);
    kick(32'h000); wait_idle();
    end_test("R9 restart writes left");

    report();
  end
endmodule